// File: doc/BRIEF.md
# Serial Flash 32 KB Block Erase Command Target

This block is the target side of a serial flash command port. It watches an SPI mode-0 link (clock idles low, data sampled on the rising clock edge, reply data changed on the falling edge) under an active-low select. It decodes three commands: set the write-enable latch, read the status byte, and erase one 32 KB block. The SPI pins are brought into the system clock domain through a synchronizer, so the serial clock must be several times slower than the system clock.

An erase command is a one-byte opcode followed by a 24-bit address. It is committed only if the select line rises exactly on the byte boundary after the last address byte, only if the write-enable latch was set when the opcode arrived, and only if the addressed block lies outside the protected top region chosen by three block-protect inputs. A committed erase sends a one-cycle request and a block index to the memory array. A cycle counter then keeps the busy flag high for a fixed, programmable time. When that time ends, busy drops and the write-enable latch is cleared. While busy is high, the host can still poll the status byte. Every other command is dropped.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Opcode 0x52 followed by three address bytes sent most significant bit first gives a commit whose `erase_blk` equals address bits 23..15. Address bits 14..0 are ignored. `erase_req` is high for exactly one clock cycle per commit.
- R2: An erase opcode that arrives while the write-enable latch is 0 is ignored: no request is made and the status is unchanged.
- R3: An erase commits only when select rises after exactly 24 address bits. Select rising after fewer bits, or after any extra clock edge, drops the command without a request and leaves the latch unchanged.
- R4: `erase_busy` rises in the cycle after `erase_req` and stays high for exactly `ERASE_CYCLES` clock cycles. During that time `erase_blk` holds its value.
- R5: Opcode 0x05 returns the status byte {6'b0, latch, busy} (bit 1 is the latch, bit 0 is busy), most significant bit first. The byte repeats for as long as select stays low.
- R6: While busy is high, only opcode 0x05 is served. An erase command sent during this time makes no request.
- R7: When the erase time ends, busy and the write-enable latch both read 0.
- R8: With `prot_bp` = n, where n is not 0, the top 2^n blocks are protected (2^(n-1) regions of 64 KB). An erase aimed at one of them makes no request and leaves the latch set. With n = 0 nothing is protected.
- R9: Opcode 0x06, sent while not busy, sets the write-enable latch.
- R10: After reset, the latch, busy, `erase_req` and `spi_miso` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from host |
| prot_bp | input | 3 | Block-protect level |
| spi_miso | output | 1 | Serial data to host |
| erase_req | output | 1 | One-cycle erase request to the array |
| erase_blk | output | BLK_W | Index of the block to erase |
| erase_busy | output | 1 | Erase in progress |

## Verification
The erase is tried with a well-formed command preceded by a latch set, which shows that the address slice and the request pulse are correct. It is also tried without the latch, which shows that the latch gate works. Two framing errors are tried: select rising four bits short, and select rising one bit or one byte late. These tell the exact-boundary rule apart from a looser check. Addresses just inside and just outside the protected window, at two protect levels and with protection off, test the window arithmetic. Status reads with two bytes per frame, taken before, during and after an erase, together with an erase sent while busy, show the busy flag, the repeating reply, the command blocking while busy and the latch clearing at the end.

// File: rtl/fe_pkg.sv
// Shared definitions for the block-erase command target.
// Assumes the array holds at least 128 blocks, so the largest protect
// window (2^7 blocks) always fits inside it.
package fe_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_ERASE = 8'h52;

    typedef enum logic [2:0] {
        ST_OP,      // waiting for opcode byte
        ST_ADDR,    // collecting address bytes
        ST_ARMED,   // all address bits in, waiting for select release
        ST_STAT,    // returning status bytes
        ST_SKIP     // frame dropped until select rises
    } fe_state_t;

    // True when block blk lies in the top 2^bp blocks of an nblocks array.
    function automatic logic blk_is_locked(input int unsigned blk,
                                           input int unsigned nblocks,
                                           input logic [2:0] bp);
        int unsigned win;
        if (bp == 3'd0) return 1'b0;
        win = 32'd1 << bp;
        return blk >= (nblocks - win);
    endfunction

endpackage

// File: rtl/fe_pin_sync.sv
// Brings the three SPI pins into the clk domain through a STAGES-deep
// flop chain, then finds the serial clock and select edges.
// Assumes the serial clock half period is longer than STAGES+2 clk cycles.
module fe_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic cs_rise,
    output logic mosi_bit
);
    localparam int NPIN = 3;
    // Idle levels: index 0 serial clock, 1 select (idle high), 2 data.
    localparam logic [NPIN-1:0] IDLE_LVL = 3'b010;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] settled;
    logic [NPIN-1:0] prev;

    assign raw = {spi_mosi, spi_cs_n, spi_sclk};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        // Purpose: metastability chain for one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{IDLE_LVL[g]}};
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign settled[g] = chain[STAGES-1];
    end

    // Purpose: previous settled levels for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_LVL;
        else        prev <= settled;
    end

    assign sclk_rise = settled[0] & ~prev[0];
    assign sclk_fall = ~settled[0] & prev[0];
    assign cs_active = ~settled[1];
    assign cs_rise   = settled[1] & ~prev[1];
    assign mosi_bit  = settled[2];
endmodule

// File: rtl/fe_byte_link.sv
// Byte framing for SPI mode 0: shifts in data on serial clock rises,
// flags each complete byte, and shifts reply data out on falls. A new
// reply byte (tx_byte) is taken at the first fall of each byte slot.
// Assumes the serial clock idles low, so the first edge after select
// falls is a rise.
module fe_byte_link #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_bit,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              on_boundary,
    output logic              spi_miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] in_sh;
    logic [BYTE_W-1:0] out_sh;
    logic              miso_q;
    logic [BYTE_W-1:0] next_in;

    assign next_in = {in_sh[BYTE_W-2:0], mosi_bit};

    // Purpose: receive shift, bit position and byte-complete strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            bit_cnt  <= '0;
            in_sh    <= '0;
            rx_valid <= 1'b0;
            if (!rst_n) rx_byte <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sclk_rise) begin
                in_sh <= next_in;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    bit_cnt  <= '0;
                    rx_valid <= 1'b1;
                    rx_byte  <= next_in;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Purpose: transmit shift, loading a fresh byte at each slot start.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            miso_q <= 1'b0;
            out_sh <= '0;
        end else if (sclk_fall) begin
            if (bit_cnt == '0) begin
                miso_q <= tx_byte[BYTE_W-1];
                out_sh <= {tx_byte[BYTE_W-2:0], 1'b0};
            end else begin
                miso_q <= out_sh[BYTE_W-1];
                out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign on_boundary = (bit_cnt == '0);
    assign spi_miso    = miso_q;
endmodule

// File: rtl/fe_cmd_engine.sv
// Command decoder: tracks the frame state, owns the write-enable latch,
// collects the erase address and decides at select release whether the
// erase commits. Produces the reply byte for status reads.
// Assumes rx_valid comes one cycle after the sclk_rise that ends a byte.
module fe_cmd_engine
    import fe_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int BLK_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_active,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             on_boundary,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic [2:0]       prot_bp,
    input  logic             busy,
    input  logic             erase_done,
    output logic             start_q,
    output logic [BLK_W-1:0] blk_q,
    output logic             wel_q,
    output logic [7:0]       tx_byte
);
    localparam int ADDR_W  = 8 * ADDR_BYTES;
    localparam int NBLK    = 1 << BLK_W;
    localparam int ACNT_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    fe_state_t         state;
    logic [ACNT_W-1:0] addr_cnt;
    logic [ADDR_W-1:0] addr_sh;
    logic [BLK_W-1:0]  tgt_blk;
    logic              commit;

    assign tgt_blk = addr_sh[ADDR_W-1 -: BLK_W];
    assign commit  = cs_rise && (state == ST_ARMED) && on_boundary && !busy
                     && !blk_is_locked(32'(tgt_blk), NBLK, prot_bp);

    // Purpose: frame state machine and address collection.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            state    <= ST_OP;
            addr_cnt <= '0;
            if (!rst_n) addr_sh <= '0;
        end else begin
            case (state)
                ST_OP: if (rx_valid) begin
                    if (rx_byte == OP_RDSR)
                        state <= ST_STAT;
                    else if (!busy && rx_byte == OP_ERASE && wel_q) begin
                        state    <= ST_ADDR;
                        addr_cnt <= '0;
                    end else
                        state <= ST_SKIP;
                end
                ST_ADDR: if (rx_valid) begin
                    addr_sh <= {addr_sh[ADDR_W-9:0], rx_byte};
                    if (addr_cnt == ACNT_W'(ADDR_BYTES - 1)) state <= ST_ARMED;
                    else addr_cnt <= addr_cnt + 1'b1;
                end
                ST_ARMED: if (sclk_rise) state <= ST_SKIP;
                default: ;
            endcase
        end
    end

    // Purpose: write-enable latch, set by its opcode and cleared at erase end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel_q <= 1'b0;
        else if (erase_done)
            wel_q <= 1'b0;
        else if (cs_active && rx_valid && state == ST_OP && !busy
                 && rx_byte == OP_WREN)
            wel_q <= 1'b1;
    end

    // Purpose: one-cycle erase request with its block index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            blk_q   <= '0;
        end else begin
            start_q <= commit;
            if (commit) blk_q <= tgt_blk;
        end
    end

    assign tx_byte = (state == ST_STAT) ? {6'b0, wel_q, busy} : 8'h00;
endmodule

// File: rtl/fe_erase_timer.sv
// Self-timed erase period: loads on start and holds busy for exactly
// CYCLES clock cycles; done marks the last busy cycle.
// Assumes start never arrives while busy.
module fe_erase_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Purpose: countdown of the remaining erase cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (start)        remain <= CNT_W'(CYCLES);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
    assign done = (remain == CNT_W'(1));
endmodule

// File: rtl/flash_erase_ctrl.sv
// Top of the block-erase command target: pin synchronizer, byte framing,
// command decoding and erase timer. Sends a one-cycle erase request with
// the block index to the array and keeps busy high for ERASE_CYCLES.
// Assumes the serial clock runs well below clk (see fe_pin_sync).
module flash_erase_ctrl #(
    parameter int SYNC_STAGES  = 2,
    parameter int ADDR_BYTES   = 3,
    parameter int BLK_W        = 9,
    parameter int ERASE_CYCLES = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    input  logic [2:0]       prot_bp,
    output logic             spi_miso,
    output logic             erase_req,
    output logic [BLK_W-1:0] erase_blk,
    output logic             erase_busy
);
    logic       sclk_rise, sclk_fall, cs_active, cs_rise, mosi_bit;
    logic [7:0] rx_byte, tx_byte;
    logic       rx_valid, on_boundary;
    logic       timer_done;
    logic       wel_now;

    fe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .cs_rise(cs_rise), .mosi_bit(mosi_bit)
    );

    fe_byte_link #(.BYTE_W(8)) u_link (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_bit(mosi_bit),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .on_boundary(on_boundary), .spi_miso(spi_miso)
    );

    fe_cmd_engine #(.ADDR_BYTES(ADDR_BYTES), .BLK_W(BLK_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .on_boundary(on_boundary),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .prot_bp(prot_bp),
        .busy(erase_busy), .erase_done(timer_done),
        .start_q(erase_req), .blk_q(erase_blk), .wel_q(wel_now),
        .tx_byte(tx_byte)
    );

    fe_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(erase_req),
        .busy(erase_busy), .done(timer_done)
    );
endmodule

// File: rtl/flash_erase_ctrl_chk.sv
// Property checker for flash_erase_ctrl, attached with bind below.
module flash_erase_ctrl_chk #(
    parameter int BLK_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       prot_bp,
    input logic             erase_req,
    input logic [BLK_W-1:0] erase_blk,
    input logic             erase_busy,
    input logic             wel
);
    localparam int NBLK = 1 << BLK_W;

    logic in_window;
    assign in_window = (prot_bp != 3'd0) &&
                       (32'(erase_blk) >= (32'(NBLK) - (32'd1 << prot_bp)));

    // R1: request is a single-cycle pulse
    a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);
    // R2: a request only happens with the latch set
    a_r2_wel_needed: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> wel);
    // R4: busy follows the request
    a_r4_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> erase_busy);
    // R4: block index holds during the erase
    a_r4_blk_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && $past(erase_busy)) |-> $stable(erase_blk));
    // R6: no new request during an erase
    a_r6_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> !erase_req);
    // R7: latch is clear once busy drops
    a_r7_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_busy) |-> !wel);
    // R8: no request into the protected window
    a_r8_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !in_window);
endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prot_bp(prot_bp), .erase_req(erase_req),
    .erase_blk(erase_blk), .erase_busy(erase_busy), .wel(wel_now)
);

// File: tb/flash_erase_ctrl_test.sv
`timescale 1ns/1ps
module flash_erase_ctrl_test;
    localparam int BLK_W  = 9;
    localparam int ECYC   = 1500;
    localparam int H      = 6;      // clk cycles per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic [2:0] prot_bp = 3'd0;
    logic spi_miso, erase_req, erase_busy;
    logic [BLK_W-1:0] erase_blk;

    int n_chk = 0, n_bad = 0;
    int req_cnt = 0, busy_cyc = 0;
    logic [BLK_W-1:0] last_blk = '0;

    always #2.5 clk = ~clk;

    flash_erase_ctrl #(.BLK_W(BLK_W), .ERASE_CYCLES(ECYC)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .prot_bp(prot_bp), .spi_miso(spi_miso),
        .erase_req(erase_req), .erase_blk(erase_blk), .erase_busy(erase_busy)
    );

    // Observes the array port: counts requests and busy cycles.
    always @(posedge clk) begin
        if (rst_n) begin
            if (erase_req) begin
                req_cnt  <= req_cnt + 1;
                last_blk <= erase_blk;
            end
            if (erase_busy) busy_cyc <= busy_cyc + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic r);
        spi_mosi = b;
        wait_clk(H);
        r = spi_miso;
        spi_sclk = 1'b1;
        wait_clk(H);
        spi_sclk = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
    endtask

    task automatic cs_begin();
        spi_cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_end();
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(4 * H);
    endtask

    task automatic send_wren();
        logic [7:0] d;
        cs_begin(); spi_byte(8'h06, d); cs_end();
    endtask

    // Erase frame; extra_bits > 0 adds clocks, < 0 drops address bits.
    task automatic send_erase(input logic [23:0] a, input int extra_bits);
        logic [7:0] d;
        logic r;
        cs_begin();
        spi_byte(8'h52, d);
        for (int i = 23; i >= 0; i--)
            if (i >= -extra_bits) spi_bit(a[i], r);
        for (int k = 0; k < extra_bits; k++) spi_bit(1'b0, r);
        cs_end();
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [7:0] d, s1, s2;
        cs_begin();
        spi_byte(8'h05, d);
        spi_byte(8'h00, s1);
        spi_byte(8'h00, s2);
        cs_end();
        check(req, int'(s1), int'(exp));
        check({req, " repeat"}, int'(s2), int'(exp));
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (erase_busy && guard < 4 * ECYC) begin
            @(negedge clk);
            guard++;
        end
        wait_clk(2);
    endtask

    task automatic t_reset();
        check("R10 erase_req", int'(erase_req), 0);
        check("R10 busy", int'(erase_busy), 0);
        check("R10 miso", int'(spi_miso), 0);
        read_status("R10 status", 8'h00);
    endtask

    task automatic t_no_wel();
        int c0 = req_cnt;
        send_erase(24'h123456, 0);
        check("R2 no request without latch", req_cnt - c0, 0);
        read_status("R2 status", 8'h00);
    endtask

    task automatic t_erase_ok();
        int c0;
        send_wren();
        read_status("R9 latch set", 8'h02);
        c0 = req_cnt;
        busy_cyc = 0;
        send_erase(24'h123456, 0);
        check("R1 one request", req_cnt - c0, 1);
        check("R1 block index", int'(last_blk), 9'h024);
        read_status("R5 status busy", 8'h03);
        send_erase(24'h7F8000, 0);
        check("R6 erase ignored while busy", req_cnt - c0, 1);
        wait_idle();
        check("R4 busy length", busy_cyc, ECYC);
        read_status("R7 after erase", 8'h00);
    endtask

    task automatic t_framing();
        int c0 = req_cnt;
        send_wren();
        send_erase(24'h008000, -4);
        check("R3 early release", req_cnt - c0, 0);
        read_status("R3 latch kept", 8'h02);
        send_erase(24'h008000, 1);
        check("R3 one bit late", req_cnt - c0, 0);
        send_erase(24'h008000, 8);
        check("R3 one byte late", req_cnt - c0, 0);
        read_status("R3 latch kept late", 8'h02);
        check("R3 not busy", int'(erase_busy), 0);
    endtask

    task automatic t_protect();
        int c0 = req_cnt;
        prot_bp = 3'd1;
        send_erase(24'hFF0000, 0);          // block 510: protected
        check("R8 bp1 top blocks locked", req_cnt - c0, 0);
        read_status("R8 latch kept", 8'h02);
        send_erase(24'hFE8000, 0);          // block 509: open
        check("R8 bp1 below window", req_cnt - c0, 1);
        check("R8 bp1 index", int'(last_blk), 509);
        wait_idle();
        prot_bp = 3'd0;
        send_wren();
        send_erase(24'hFFFFFF, 0);          // block 511, no protection
        check("R8 bp0 top block", req_cnt - c0, 2);
        check("R1 low bits ignored", int'(last_blk), 511);
        wait_idle();
        prot_bp = 3'd3;
        send_wren();
        send_erase(24'hFC0000, 0);          // block 504: protected
        check("R8 bp3 window edge", req_cnt - c0, 2);
        send_erase(24'hFB8000, 0);          // block 503: open
        check("R8 bp3 below window", req_cnt - c0, 3);
        check("R8 bp3 index", int'(last_blk), 503);
        wait_idle();
        read_status("R7 final", 8'h00);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_no_wel();
        t_erase_ok();
        t_framing();
        t_protect();
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule